// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of a 16-bit successive-approximation converter. It watches an active-low convert request, makes sure the sampling capacitor has tracked the input for a minimum number of clock periods, and then tests one result bit per clock edge. For each test it drives a trial word to an external DAC and reads back a single comparator bit. Bits are decided from the most significant down. The analog array, the comparator and calibration sit outside this block; calibration appears only as a busy input that holds off new conversions.

While a conversion runs, an end-of-conversion flag is high. It is delayed by one clock at both its rising and its falling edge, so it frames the serial bit stream that leaves the block as each bit is decided. When the last bit is known, the result is copied into a holding register and a one-cycle done pulse is raised. If the flag is wired straight back to the convert request, the block runs conversions back to back, with the acquisition guard setting the gap between them. A two-bit range input selects shutdown, unipolar or bipolar operation. The range in force at the start of a conversion is latched for the DAC.

All state changes on the rising edge of `clk`, which is the active conversion-clock edge.

Top module: `sar_seq`

## Requirements
- R1: After `rst_n` is released, `eoc`, `done`, `dout`, `bipolar` and `trial` are all 0, and the guard already counts as satisfied, so a request seen at the first edge starts a conversion at that edge.
- R2: On the start edge, `trial` becomes 0x8000. On each of the next 16 edges the bit under test is kept at 1 if `cmp` is 0 and cleared if `cmp` is 1, and the next lower bit is set to 1. With an ideal comparator (`cmp` = trial > input) the final word equals the input.
- R3: An edge counter is cleared at the edge that decides the last bit and saturates at 3. A request seen while the counter is below 3 is remembered, and the conversion starts on the fourth edge after that end edge, even if `conv_n` has gone high again.
- R4: When the counter is at 3 (at least three edges since the last end), a request sampled low at an edge starts the conversion at that same edge.
- R5: A `conv_n` low level seen while a conversion is running is neither started nor remembered. A conversion always runs all 16 bit edges.
- R6: `eoc` rises one cycle after the start edge, falls one cycle after the end edge, and stays high for exactly 16 cycles per conversion.
- R7: With `cs_n` low, `dout` shows the bit decided at the previous edge, so bits leave MSB first and are valid in the 16 cycles that follow the second through seventeenth edges after the start edge. With `cs_n` high, `dout` is 0.
- R8: `mode` 2'b00 is shutdown: no conversion starts and a remembered request is dropped. 2'b01 is unipolar and 2'b10 or 2'b11 is bipolar. `bipolar` takes the value of `mode[1]` at the start edge and holds it until the next start.
- R9: While `cal_busy` is high, no conversion starts and a remembered request is dropped.
- R10: At the end edge the finished word is copied to `result`, and `done` is high for exactly the one cycle that follows.
- R11: With `conv_n` driven from `eoc`, conversions repeat without end: 16 cycles with `eoc` high, then 4 cycles low.
- R12: Pulling `rst_n` low in the middle of a conversion stops it at once. `eoc` goes low, no `done` follows and `trial` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the rising edge is the active edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_n | input | 1 | Active-low convert request |
| cmp | input | 1 | Comparator: 1 means the trial word exceeds the input |
| mode | input | 2 | 00 shutdown, 01 unipolar, 1x bipolar |
| cal_busy | input | 1 | High while calibration owns the converter |
| cs_n | input | 1 | Active-low enable of the serial output |
| trial | output | 16 | Trial word to the external DAC |
| bipolar | output | 1 | Range latched at the start of the conversion |
| eoc | output | 1 | End-of-conversion framing flag |
| dout | output | 1 | Serial result bit, MSB first |
| result | output | 16 | Holding register with the last finished result |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The hardest case to reach is a short request that lands inside the acquisition window just after a conversion ends. It must be remembered even after `conv_n` rises again, and the conversion must start exactly on the fourth edge. The bench gets there by dropping `conv_n` for a single cycle straight after `eoc` falls, then checks `eoc` and `trial` edge by edge. It reaches the same guard from the other side by tying `conv_n` to `eoc` and measuring the gap between frames. A scoreboard checks every result against the analog input level that an ideal comparator model was given.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W   = 16,
  parameter int ACQ = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_n,
  input  logic         cmp,
  input  logic [1:0]   mode,
  input  logic         cal_busy,
  input  logic         cs_n,
  output logic [W-1:0] trial,
  output logic         bipolar,
  output logic         eoc,
  output logic         dout,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int IW = $clog2(W);
  localparam int AW = $clog2(ACQ + 1);
  localparam logic [AW-1:0] ACQ_MAX = AW'(ACQ - 1);
  localparam logic [IW-1:0] TOP = IW'(W - 1);

  logic          busy_q, pend_q, dec_q, dec_vld_q, dout_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] acq_q;
  logic [W-1:0]  nxt;

  wire run_ok = (mode != 2'b00) && !cal_busy;
  wire start  = !busy_q && run_ok && (!conv_n || pend_q) && (acq_q == ACQ_MAX);

  always_comb begin
    nxt = trial;
    nxt[idx_q] = ~cmp;
    if (idx_q != '0) nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      idx_q     <= '0;
      acq_q     <= ACQ_MAX;
      trial     <= '0;
      result    <= '0;
      bipolar   <= 1'b0;
      eoc       <= 1'b0;
      done      <= 1'b0;
      dec_q     <= 1'b0;
      dec_vld_q <= 1'b0;
      dout_q    <= 1'b0;
    end else begin
      eoc       <= busy_q;
      done      <= busy_q && (idx_q == '0);
      dec_vld_q <= busy_q;
      if (busy_q) dec_q <= ~cmp;
      if (dec_vld_q) dout_q <= dec_q;
      if (start) begin
        busy_q  <= 1'b1;
        pend_q  <= 1'b0;
        idx_q   <= TOP;
        trial   <= {1'b1, {(W-1){1'b0}}};
        bipolar <= mode[1];
      end else if (busy_q) begin
        trial <= nxt;
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          result <= nxt;
          acq_q  <= '0;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else begin
        if (acq_q != ACQ_MAX) acq_q <= acq_q + 1'b1;
        pend_q <= run_ok && (pend_q || !conv_n);
      end
    end
  end

  assign dout = !cs_n && dout_q;

  logic [3:0] idle_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idle_run <= 4'hF;
    else if (busy_q)       idle_run <= '0;
    else if (idle_run != 4'hF) idle_run <= idle_run + 1'b1;
  end

  a_r3_acq_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idle_run >= 4'(ACQ)));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != '0) |=> (busy_q && idx_q == $past(idx_q) - 1'b1));
  a_r6_eoc_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (busy_q && idx_q == TOP - 1'b1));
  a_r7_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout);
  a_r8_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && mode == 2'b00) |=> !busy_q);
  a_r9_cal_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cal_busy) |=> !busy_q);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_drv = 1'b1;
  logic tie = 1'b0;
  logic [1:0] mode = 2'b01;
  logic cal_busy = 1'b0;
  logic cs_n = 1'b0;
  logic [15:0] vin = '0;
  logic sb_en = 1'b1;
  logic [15:0] trial, result;
  logic bipolar, eoc, dout, done, conv_n, cmp;
  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  assign conv_n = tie ? eoc : conv_drv;
  assign cmp = (trial > vin);

  sar_seq uut (.clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cmp(cmp), .mode(mode),
    .cal_busy(cal_busy), .cs_n(cs_n), .trial(trial), .bipolar(bipolar), .eoc(eoc),
    .dout(dout), .result(result), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_en && done) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected done", 32'(result), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R10 R2 result", 32'(result), 32'(e));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns at the negedge after the start edge S
  task automatic kick(input logic [15:0] v);
    idle(5);
    vin = v;
    conv_drv = 1'b0;
    @(negedge clk);
    conv_drv = 1'b1;
    chk(trial == 16'h8000, "R2 R4 trial after start", 32'(trial), 32'h8000);
    chk(eoc == 1'b0, "R6 eoc low on start cycle", 32'(eoc), 0);
  endtask

  // called at negedge after S, returns at negedge after S+17
  task automatic watch(input logic [15:0] v, input bit pulse_mid);
    int hi = 0;
    if (sb_en) exp_q.push_back(v);
    for (int k = 1; k <= 17; k++) begin
      if (pulse_mid) conv_drv = !(k >= 5 && k <= 7);
      @(negedge clk);
      if (eoc) hi++;
      chk(eoc == (k <= 16), "R6 eoc frame", 32'(eoc), 32'(k <= 16));
      if (k >= 2) chk(dout == (cs_n ? 1'b0 : v[17-k]), "R7 serial bit", 32'(dout), 32'(cs_n ? 1'b0 : v[17-k]));
      if (k == 1) chk(trial[15:14] == {v[15], 1'b1}, "R2 first decision", 32'(trial[15:14]), 32'({v[15], 1'b1}));
      chk(done == (k == 16), "R10 done timing", 32'(done), 32'(k == 16));
    end
    conv_drv = 1'b1;
    chk(hi == 16, "R6 eoc width", 32'(hi), 16);
  endtask

  initial begin
    #(20ns * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    @(negedge clk);
    chk({eoc, done, dout, bipolar} == 4'b0 && trial == 0, "R1 reset state", 32'({eoc, done, dout, bipolar}), 0);
    rst_n = 1'b1;
    // R1: first request starts immediately
    vin = 16'h1234; conv_drv = 1'b0;
    @(negedge clk); conv_drv = 1'b1;
    chk(trial == 16'h8000, "R1 start at first edge", 32'(trial), 32'h8000);
    watch(16'h1234, 0);

    kick(16'h0000); watch(16'h0000, 0);
    kick(16'hFFFF); watch(16'hFFFF, 0);
    kick(16'h8000); watch(16'h8000, 0);
    kick(16'hA5A5); watch(16'hA5A5, 0);
    kick(16'h7FFF); watch(16'h7FFF, 0);

    // R3: one-cycle request just after eoc falls
    vin = 16'h0F0F; conv_drv = 1'b0;
    @(negedge clk); conv_drv = 1'b1;
    chk(eoc == 0, "R3 no start E+2", 32'(eoc), 0);
    @(negedge clk);
    chk(eoc == 0 && trial != 16'h8000, "R3 no start E+3", 32'(trial), 0);
    @(negedge clk);
    chk(trial == 16'h8000, "R3 start on fourth edge", 32'(trial), 32'h8000);
    watch(16'h0F0F, 0);

    // R5: request pulse mid-conversion ignored
    kick(16'h3C3C); watch(16'h3C3C, 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (eoc) n++; end
    chk(n == 0, "R5 no extra conversion", 32'(n), 0);

    // R7: cs_n high keeps dout low
    cs_n = 1'b1; kick(16'hFFFF); watch(16'hFFFF, 0); cs_n = 1'b0;

    // R8: shutdown blocks, drops pending, bipolar latch
    mode = 2'b00; conv_drv = 1'b0; n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (eoc || trial == 16'h8000) n++; end
    chk(n == 0, "R8 shutdown blocks start", 32'(n), 0);
    conv_drv = 1'b1; @(negedge clk); mode = 2'b01; n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (eoc) n++; end
    chk(n == 0, "R8 pending dropped in shutdown", 32'(n), 0);
    mode = 2'b10; kick(16'h5555);
    chk(bipolar == 1'b1, "R8 bipolar latched", 32'(bipolar), 1);
    mode = 2'b01;
    watch(16'h5555, 0);
    chk(bipolar == 1'b1, "R8 bipolar held", 32'(bipolar), 1);
    kick(16'h00FF);
    chk(bipolar == 1'b0, "R8 unipolar latched", 32'(bipolar), 0);
    watch(16'h00FF, 0);

    // R9: calibration busy blocks
    cal_busy = 1'b1; conv_drv = 1'b0; n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (eoc) n++; end
    chk(n == 0, "R9 cal_busy blocks", 32'(n), 0);
    conv_drv = 1'b1; @(negedge clk); cal_busy = 1'b0; n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (eoc) n++; end
    chk(n == 0, "R9 pending dropped", 32'(n), 0);
    kick(16'hC001); watch(16'hC001, 0);

    // R11: eoc tied to convert
    sb_en = 1'b0; idle(6); vin = 16'h4242; tie = 1'b1;
    n = 0;
    while (!eoc && n < 40) begin @(negedge clk); n++; end
    for (int r = 0; r < 2; r++) begin
      n = 0; while (eoc && n < 40) begin @(negedge clk); n++; end
      chk(n == 16, "R11 frame high", 32'(n), 16);
      n = 0; while (!eoc && n < 40) begin @(negedge clk); n++; end
      chk(n == 4, "R11 gap low", 32'(n), 4);
    end
    chk(result == 16'h4242, "R11 loop result", 32'(result), 32'h4242);
    tie = 1'b0; idle(25);

    // R12: reset mid-conversion
    kick(16'h9999); idle(5);
    rst_n = 1'b0; @(negedge clk);
    chk(eoc == 0 && done == 0 && trial == 0, "R12 reset aborts", 32'(trial), 0);
    rst_n = 1'b1; n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done || eoc) n++; end
    chk(n == 0, "R12 no done after abort", 32'(n), 0);
    sb_en = 1'b1;
    kick(16'h2468); watch(16'h2468, 0);
    idle(3);
    chk(exp_q.size() == 0, "R10 all results seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule